// File: doc/BRIEF.md
# Multi-Cycle Shift Unit

This block is a 32-bit shifter meant to sit beside a small integer ALU. On a start strobe it captures the operand, the 5-bit amount and the operation. It raises busy while it works. It then delivers the result together with a one-cycle done strobe. The three operations are logical left, logical right and arithmetic right. Arithmetic right fills the vacated positions with the operand's sign bit.

Two build-time parameters choose how the shift is carried out, and every choice keeps the same start/busy/done handshake:
- `USE_BARREL` set true builds a full barrel shifter with a fixed one-cycle latency.
- Otherwise the unit iterates. With `USE_COARSE` true it takes 4-position strides first and single-position strides after them. With `USE_COARSE` false it moves one position per cycle.

The caller waits for done and does not depend on a fixed latency.

Top module: `shift_unit`

## Requirements
- R1: With op_i = 0 (logical left), the result is the operand shifted left by amt_i, with zeros entering at bit 0.
- R2: With op_i = 1 (logical right), the result is the operand shifted right by amt_i, with zeros entering at bit 31.
- R3: With op_i = 2 (arithmetic right), the result is the operand shifted right by amt_i, with every vacated bit equal to the operand's bit 31, in every architecture.
- R4: In the one-position-per-cycle architecture, done rises amt_i + 1 clock edges after the edge that accepted start.
- R5: In the stride architecture, done rises floor(amt_i/4) + (amt_i mod 4) + 1 edges after the accepting edge.
- R6: In the barrel architecture, done rises exactly 1 edge after the accepting edge, for any amount.
- R7: After an accepted start, busy is high up to the completion edge. At that edge busy falls and done is high for exactly one cycle. Busy and done are never high together.
- R8: An amount of 0 returns the operand unchanged after 1 edge in every architecture.
- R9: A start that arrives while busy is high is ignored. The running operation finishes with its own inputs and latency, and no extra done follows.
- R10: result_o changes only in a cycle where done_o is high, and otherwise holds the last completed result.
- R11: Synchronous reset drives busy and done low and clears the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, accepted only when busy is low |
| op_i | input | 2 | Operation: 0 logical left, 1 logical right, 2 arithmetic right |
| amt_i | input | 5 | Shift amount, 0 to 31 |
| operand_i | input | 32 | Value to shift |
| busy_o | output | 1 | High while an operation is in progress |
| done_o | output | 1 | One-cycle strobe marking a valid result |
| result_o | output | 32 | Last completed result |

## Verification
The bench runs all three architectures side by side on the same inputs. For every accepted start, it counts the edges until each instance raises done. That count must be 1 for the barrel instance, amt+1 for the serial instance and floor(amt/4)+(amt mod 4)+1 for the stride instance.

Outputs are sampled one nanosecond after each rising edge. The sampling window stays open for 40 edges, well beyond the longest latency, so a late or repeated done is caught as well. The result is compared both in the done cycle and at the end of the window, which covers the hold requirement.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int DATA_W      = 32;
    localparam int AMT_W       = $clog2(DATA_W);
    localparam int COARSE_STEP = 4;
    localparam int CRS_SH      = $clog2(COARSE_STEP);

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [AMT_W-1:0]  amt_t;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RL = 2'd1,
        SH_RA = 2'd2
    } shop_e;

    typedef struct packed {
        word_t data;
        amt_t  amt;
        shop_e op;
    } shreq_t;

    function automatic word_t shift_by(word_t v, shop_e op, amt_t n);
        case (op)
            SH_LL:   return v << n;
            SH_RA:   return word_t'($signed(v) >>> n);
            default: return v >> n;
        endcase
    endfunction

    function automatic int unsigned steps_for(amt_t n, bit coarse);
        int unsigned u;
        u = int'(n);
        if (coarse) return (u / COARSE_STEP) + (u % COARSE_STEP);
        return u;
    endfunction
endpackage

// File: rtl/shift_iter_core.sv
module shift_iter_core
    import shift_pkg::*;
#(
    parameter bit COARSE = 1'b1
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  shreq_t req_i,
    output logic   busy_o,
    output logic   done_o,
    output word_t  result_o
);
    word_t work_q;
    shop_e op_q;
    amt_t  crs_q, fine_q;
    amt_t  crs_ld, fine_ld;

    generate
        if (COARSE) begin : g_stride
            assign crs_ld  = amt_t'(req_i.amt >> CRS_SH);
            assign fine_ld = amt_t'(req_i.amt[CRS_SH-1:0]);
        end else begin : g_single
            assign crs_ld  = '0;
            assign fine_ld = req_i.amt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            result_o <= '0;
            work_q   <= '0;
            op_q     <= SH_LL;
            crs_q    <= '0;
            fine_q   <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    work_q <= req_i.data;
                    op_q   <= req_i.op;
                    crs_q  <= crs_ld;
                    fine_q <= fine_ld;
                end
            end else if (crs_q != '0) begin
                work_q <= shift_by(work_q, op_q, amt_t'(COARSE_STEP));
                crs_q  <= crs_q - amt_t'(1);
            end else if (fine_q != '0) begin
                work_q <= shift_by(work_q, op_q, amt_t'(1));
                fine_q <= fine_q - amt_t'(1);
            end else begin
                busy_o   <= 1'b0;
                done_o   <= 1'b1;
                result_o <= work_q;
            end
        end
    end

    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    a_r7_not_both: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && done_o));
    a_r8_zero_fast: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o && req_i.amt == '0) |=> busy_o ##1 done_o);
    a_r9_op_kept: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> $stable(op_q));
endmodule

// File: rtl/shift_barrel_core.sv
module shift_barrel_core
    import shift_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   start_i,
    input  shreq_t req_i,
    output logic   busy_o,
    output logic   done_o,
    output word_t  result_o
);
    shreq_t req_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o   <= 1'b0;
            done_o   <= 1'b0;
            result_o <= '0;
            req_q    <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    req_q  <= req_i;
                end
            end else begin
                busy_o   <= 1'b0;
                done_o   <= 1'b1;
                result_o <= shift_by(req_q.data, req_q.op, req_q.amt);
            end
        end
    end

    a_r6_fixed_latency: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> busy_o ##1 (done_o && !busy_o));
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter bit USE_BARREL = 1'b0,
    parameter bit USE_COARSE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic [AMT_W-1:0]  amt_i,
    input  logic [DATA_W-1:0] operand_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);
    shreq_t req;
    assign req = '{data: operand_i, amt: amt_i, op: shop_e'(op_i)};

    generate
        if (USE_BARREL) begin : g_barrel
            shift_barrel_core u_core (
                .clk(clk), .rst(rst), .start_i(start_i), .req_i(req),
                .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
            );
        end else begin : g_iter
            shift_iter_core #(.COARSE(USE_COARSE)) u_core (
                .clk(clk), .rst(rst), .start_i(start_i), .req_i(req),
                .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
            );
        end
    endgenerate

    // Observation registers used only by the properties below.
    shreq_t     chk_q;
    logic [7:0] lat_q;
    logic [7:0] exp_lat;

    always_ff @(posedge clk) begin
        if (rst) begin
            chk_q <= '0;
            lat_q <= '0;
        end else if (start_i && !busy_o) begin
            chk_q <= req;
            lat_q <= '0;
        end else if (busy_o) begin
            lat_q <= lat_q + 8'd1;
        end
    end

    always_comb begin
        if (USE_BARREL) exp_lat = 8'd1;
        else            exp_lat = 8'(steps_for(chk_q.amt, USE_COARSE) + 1);
    end

    a_r5_latency: assert property (@(posedge clk) disable iff (rst)
        done_o |-> lat_q == exp_lat);  // also covers R4 and R6
    a_r3_sign_fill: assert property (@(posedge clk) disable iff (rst)
        (done_o && chk_q.op == SH_RA) |-> result_o[DATA_W-1] == chk_q.data[DATA_W-1]);
    a_r8_zero_pass: assert property (@(posedge clk) disable iff (rst)
        (done_o && chk_q.amt == '0) |-> result_o == chk_q.data);
    a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
        $changed(result_o) |-> done_o);
    a_r11_reset: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && result_o == '0));
endmodule

// File: tb/sim_shift_unit.sv
`timescale 1ns/1ps
module sim_shift_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = 2'd0;
    logic [4:0]  amt_i = 5'd0;
    logic [31:0] operand_i = 32'd0;
    logic        busy_w [3];
    logic        done_w [3];
    logic [31:0] res_w  [3];

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // u0: stride, u1: one position per cycle, u2: barrel
    shift_unit #(.USE_BARREL(1'b0), .USE_COARSE(1'b1)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .amt_i(amt_i),
        .operand_i(operand_i), .busy_o(busy_w[0]), .done_o(done_w[0]), .result_o(res_w[0]));
    shift_unit #(.USE_BARREL(1'b0), .USE_COARSE(1'b0)) u1 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .amt_i(amt_i),
        .operand_i(operand_i), .busy_o(busy_w[1]), .done_o(done_w[1]), .result_o(res_w[1]));
    shift_unit #(.USE_BARREL(1'b1), .USE_COARSE(1'b0)) u2 (
        .clk(clk), .rst(rst), .start_i(start_i), .op_i(op_i), .amt_i(amt_i),
        .operand_i(operand_i), .busy_o(busy_w[2]), .done_o(done_w[2]), .result_o(res_w[2]));

    task automatic chk(bit ok, string req, int inst, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s u%0d act=%h exp=%h", req, inst, act, exp);
        end
    endtask

    function automatic logic [31:0] model(int op, int amt, logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) begin
            if (op == 0)      r[i] = (i >= amt) ? v[i-amt] : 1'b0;
            else if (op == 1) r[i] = (i + amt <= 31) ? v[i+amt] : 1'b0;
            else              r[i] = (i + amt <= 31) ? v[i+amt] : v[31];
        end
        return r;
    endfunction

    task automatic run_vec(int op, int amt, logic [31:0] val, bit dbl);
        logic [31:0] exp;
        int lat [3];
        int first [3];
        int ndone [3];
        logic [31:0] got [3];
        string rtag;
        string ltag [3];
        exp = model(op, amt, val);
        lat[0] = amt / 4 + amt % 4 + 1;
        lat[1] = amt + 1;
        lat[2] = 1;
        ltag[0] = "R5"; ltag[1] = "R4"; ltag[2] = "R6";
        rtag = (op == 0) ? "R1" : (op == 1) ? "R2" : "R3";
        for (int i = 0; i < 3; i++) begin
            first[i] = -1; ndone[i] = 0; got[i] = '0;
        end
        @(negedge clk);
        start_i = 1'b1; op_i = 2'(op); amt_i = 5'(amt); operand_i = val;
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++)
            chk(busy_w[i] == 1'b1, "R7", i, 32'(busy_w[i]), 32'd1);
        if (dbl) begin
            op_i = 2'((op + 1) % 3); amt_i = ~5'(amt); operand_i = ~val;
        end else begin
            start_i = 1'b0;
        end
        for (int k = 1; k <= 40; k++) begin
            @(posedge clk); #1;
            if (k == 1) start_i = 1'b0;
            for (int i = 0; i < 3; i++) begin
                if (done_w[i]) begin
                    ndone[i]++;
                    if (busy_w[i]) chk(1'b0, "R7", i, 32'd1, 32'd0);
                    if (first[i] < 0) begin
                        first[i] = k;
                        got[i] = res_w[i];
                    end
                end
            end
        end
        for (int i = 0; i < 3; i++) begin
            chk(ndone[i] == 1, dbl ? "R9" : "R7", i, 32'(ndone[i]), 32'd1);
            chk(first[i] == lat[i], (amt == 0) ? "R8" : ltag[i], i, 32'(first[i]), 32'(lat[i]));
            chk(got[i] == exp, dbl ? "R9" : rtag, i, got[i], exp);
            chk(res_w[i] == exp, "R10", i, res_w[i], exp);
            chk(busy_w[i] == 1'b0, "R7", i, 32'(busy_w[i]), 32'd0);
        end
    endtask

    initial begin
        logic [31:0] pats [3];
        pats[0] = 32'h8000_0001;
        pats[1] = 32'h7FF0_1234;
        pats[2] = 32'hDEAD_BEEF;
        repeat (3) @(posedge clk);
        #1;
        for (int i = 0; i < 3; i++) begin
            chk(busy_w[i] == 1'b0, "R11", i, 32'(busy_w[i]), 32'd0);
            chk(done_w[i] == 1'b0, "R11", i, 32'(done_w[i]), 32'd0);
            chk(res_w[i] == 32'd0, "R11", i, res_w[i], 32'd0);
        end
        @(negedge clk);
        rst = 1'b0;
        for (int op = 0; op < 3; op++)
            for (int amt = 0; amt < 32; amt++)
                for (int p = 0; p < 3; p++)
                    run_vec(op, amt, pats[p], 1'b0);
        run_vec(2, 31, 32'h8000_0000, 1'b1);
        run_vec(0, 31, 32'h0000_0001, 1'b1);
        run_vec(1, 0,  32'hCAFE_F00D, 1'b1);
        run_vec(2, 7,  32'h9234_5678, 1'b1);
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule